// File: doc/BRIEF.md
# PAM4 Lane Framer with Termination-Aware Precoder

This block takes the bit stream for one transmit lane and turns it into framed PAM4 symbols, one 2-bit Gray-coded symbol per output handshake. A lane frame is a grid of `ROWS` rows of `SYMS_PER_ROW` symbols, which is 88 x 32 symbols by default. The first `OVH_SYMS` symbols of a frame come from a parallel overhead input. The last symbol of every row is a termination symbol. All other symbols take two payload bits from a serial input.

Every symbol passes through a 1/(1+D) modulo-4 precoder. The termination is applied inside the precoder loop. A termination symbol takes one payload bit and is forced to the outer level that bit selects. The forced level then becomes the feedback value for the next symbol. With the default sizes a frame carries 5540 payload bits, 4 overhead bits and 88 termination bits, which is 5632 bit positions in total.

Both stream edges use valid/ready. An output symbol is held unchanged while `out_valid` is high and `out_ready` is low. A serial bit is accepted only when it can be stored. The bit that completes a symbol is refused (`in_ready` low) until the output register is free. During overhead symbols no serial bit is taken at all.

Top module: `pam4_lane_framer`

## Requirements
- R1: A frame has ROWS*SYMS_PER_ROW symbols and consumes exactly ROWS*(2*SYMS_PER_ROW-1) - 2*OVH_SYMS serial bits. With the defaults this is 2816 symbols and 5540 bits.
- R2: The first OVH_SYMS symbols of each frame take their input value from `ovh_bits` and consume no serial bit. Symbol 0 uses `ovh_bits[2*OVH_SYMS-1 -: 2]`, the next symbol uses the next lower pair, and so on. The whole field is sampled at the handshake of the frame's symbol 0, and later overhead symbols use that sampled copy.
- R3: A payload symbol's input value is x = 2*first + second, where first and second are the two serial bits in arrival order.
- R4: The precoder output level is L(n) = (x(n) - L(n-1)) mod 4, with L(-1) = 2 after reset. With overhead value 4'b1010 followed by payload bits 1,0,1,0,0,0,1,1,1,0,0,0, the first eight levels are 0,2,0,2,2,1,1,3.
- R5: The last symbol of every row consumes one serial bit. Its level is 3 if that bit is 1 and 0 if it is 0, and that level feeds back as L(n-1) for the next symbol.
- R6: `out_sym` is the Gray code of the level: 0 -> 00, 1 -> 01, 2 -> 11, 3 -> 10. A termination symbol is therefore always 00 or 10.
- R7: `out_term` is high exactly on frame symbol positions SYMS_PER_ROW-1, 2*SYMS_PER_ROW-1, and so on.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sym` and `out_term` stay unchanged. Symbols are never lost or duplicated, whatever the pattern of `in_valid` and `out_ready`.
- R9: After reset `out_valid` is low. `in_ready` is low because the first slot is an overhead symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Serial payload bit offered |
| in_data | input | 1 | Serial payload bit |
| in_ready | output | 1 | Block accepts the offered bit |
| ovh_bits | input | 2*OVH_SYMS | Overhead field for the next frame |
| out_valid | output | 1 | Output symbol present |
| out_ready | input | 1 | Downstream takes the symbol |
| out_sym | output | 2 | Gray-coded PAM4 symbol |
| out_term | output | 1 | Symbol is a row termination symbol |

## Verification
The bench builds the block with ROWS=3, SYMS_PER_ROW=10 and OVH_SYMS=2, so one frame is only 30 symbols. Twenty frames then cover many row and frame wraps, many overhead recaptures, and termination symbols driven by both bit values. The same run applies steady flow, light throttling and heavy back-pressure on both edges. Each output symbol's Gray code and marker are compared with a model computed from the requirements. A row length of ten keeps the reference precoder vector clear of the first termination slot.

// File: rtl/pam4_lane_pkg.sv
package pam4_lane_pkg;

  typedef enum logic [1:0] {
    SLOT_OVH  = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_TERM = 2'd2
  } slot_e;

  // Level index 0..3 (-1 .. +1) to line code
  function automatic logic [1:0] lvl2gray(input logic [1:0] lvl);
    return {lvl[1], lvl[1] ^ lvl[0]};
  endfunction

endpackage

// File: rtl/pam4_slot_seq.sv
module pam4_slot_seq
  import pam4_lane_pkg::*;
#(
  parameter int ROWS         = 88,
  parameter int SYMS_PER_ROW = 32,
  parameter int OVH_SYMS     = 2,
  parameter int OIW          = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  output slot_e          slot,
  output logic [OIW-1:0] ovh_idx,
  output logic           frame_first
);
  localparam int CW = (SYMS_PER_ROW > 1) ? $clog2(SYMS_PER_ROW) : 1;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [CW-1:0] LAST_COL = CW'(SYMS_PER_ROW - 1);
  localparam logic [CW-1:0] OVH_LIM  = CW'(OVH_SYMS);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic [CW-1:0] col;
  logic [RW-1:0] row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (adv) begin
      if (col == LAST_COL) begin
        col <= '0;
        row <= (row == LAST_ROW) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  always_comb begin
    if (col == LAST_COL)                   slot = SLOT_TERM;
    else if (row == '0 && col < OVH_LIM)   slot = SLOT_OVH;
    else                                   slot = SLOT_DATA;
    ovh_idx     = col[OIW-1:0];
    frame_first = (row == '0) && (col == '0);
  end

endmodule

// File: rtl/pam4_bit_gather.sv
module pam4_bit_gather
  import pam4_lane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_data,
  output logic       in_ready,
  input  slot_e      slot,
  input  logic       out_space,
  output logic       fire,
  output logic [1:0] dbits
);
  logic held;
  logic have;

  always_comb begin
    in_ready = 1'b0;
    fire     = 1'b0;
    dbits    = {held, in_data};
    case (slot)
      SLOT_OVH: begin
        fire = out_space;
      end
      SLOT_TERM: begin
        in_ready = out_space;
        fire     = out_space && in_valid;
        dbits    = {in_data, 1'b0};
      end
      default: begin
        if (!have) begin
          in_ready = 1'b1;
        end else begin
          in_ready = out_space;
          fire     = out_space && in_valid;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      have <= 1'b0;
    end else if (slot == SLOT_DATA && !have && in_valid) begin
      held <= in_data;
      have <= 1'b1;
    end else if (fire) begin
      have <= 1'b0;
    end
  end

endmodule

// File: rtl/pam4_precoder.sv
module pam4_precoder
  import pam4_lane_pkg::*;
#(
  parameter logic [1:0] P_INIT = 2'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  slot_e      slot,
  input  logic [1:0] x,
  input  logic       out_ready,
  output logic       out_space,
  output logic       out_valid,
  output logic [1:0] out_sym,
  output logic       out_term
);
  logic [1:0] prev;
  logic [1:0] lvl;

  always_comb begin
    if (slot == SLOT_TERM) lvl = {2{x[1]}};
    else                   lvl = x - prev;
    out_space = !out_valid || out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev      <= P_INIT;
      out_valid <= 1'b0;
      out_sym   <= 2'b00;
      out_term  <= 1'b0;
    end else if (fire) begin
      prev      <= lvl;
      out_sym   <= lvl2gray(lvl);
      out_term  <= (slot == SLOT_TERM);
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pam4_lane_framer.sv
module pam4_lane_framer
  import pam4_lane_pkg::*;
#(
  parameter int         ROWS         = 88,
  parameter int         SYMS_PER_ROW = 32,
  parameter int         OVH_SYMS     = 2,
  parameter logic [1:0] P_INIT       = 2'd2,
  localparam int        OVH_BITS     = 2 * OVH_SYMS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_data,
  output logic                in_ready,
  input  logic [OVH_BITS-1:0] ovh_bits,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          out_sym,
  output logic                out_term
);
  localparam int OIW = (OVH_SYMS > 1) ? $clog2(OVH_SYMS) : 1;

  slot_e               slot;
  logic [OIW-1:0]      ovh_idx;
  logic                frame_first;
  logic                fire;
  logic                out_space;
  logic [1:0]          dbits;
  logic [1:0]          ovh_x;
  logic [1:0]          x;
  logic [OVH_BITS-1:0] ovh_q;
  logic [OVH_BITS-1:0] ovh_src;

  pam4_slot_seq #(
    .ROWS(ROWS), .SYMS_PER_ROW(SYMS_PER_ROW), .OVH_SYMS(OVH_SYMS), .OIW(OIW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(fire),
    .slot(slot), .ovh_idx(ovh_idx), .frame_first(frame_first)
  );

  pam4_bit_gather u_gather (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .slot(slot), .out_space(out_space),
    .fire(fire), .dbits(dbits)
  );

  // Overhead field: live on symbol 0, captured copy afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ovh_q <= '0;
    else if (fire && frame_first)  ovh_q <= ovh_bits;
  end

  always_comb begin
    ovh_src = frame_first ? ovh_bits : ovh_q;
    ovh_x   = 2'b00;
    for (int j = 0; j < OVH_SYMS; j++) begin
      if (ovh_idx == OIW'(j)) ovh_x = ovh_src[OVH_BITS-1-2*j -: 2];
    end
    x = (slot == SLOT_OVH) ? ovh_x : dbits;
  end

  pam4_precoder #(.P_INIT(P_INIT)) u_pre (
    .clk(clk), .rst_n(rst_n), .fire(fire), .slot(slot), .x(x),
    .out_ready(out_ready), .out_space(out_space), .out_valid(out_valid),
    .out_sym(out_sym), .out_term(out_term)
  );

endmodule

// File: rtl/pam4_lane_framer_chk.sv
module pam4_lane_framer_chk #(
  parameter int SYMS_PER_ROW = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_sym,
  input logic       out_term
);
  localparam int CW = (SYMS_PER_ROW > 1) ? $clog2(SYMS_PER_ROW) : 1;
  localparam logic [CW-1:0] LAST_COL = CW'(SYMS_PER_ROW - 1);

  logic [CW-1:0] ccol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ccol <= '0;
    else if (out_valid && out_ready) ccol <= (ccol == LAST_COL) ? '0 : ccol + 1'b1;
  end

  // R5
  term_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_term) |-> (out_sym == 2'b10 || out_sym == 2'b00));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_term)));

  // R7
  term_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_term == (ccol == LAST_COL)));

  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid);

endmodule

bind pam4_lane_framer pam4_lane_framer_chk #(.SYMS_PER_ROW(SYMS_PER_ROW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_sym(out_sym), .out_term(out_term)
);

// File: tb/pam4_lane_framer_bench.sv
module pam4_lane_framer_bench;
  localparam int TR    = 3;
  localparam int TS    = 10;
  localparam int TO    = 2;
  localparam int FS    = TR * TS;
  localparam int NF    = 20;
  localparam int NSYM  = NF * FS;
  localparam int LIMIT = 50000;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_data, in_ready;
  logic [2*TO-1:0] ovh_bits;
  logic out_valid, out_ready, out_term;
  logic [1:0] out_sym;

  always #5 clk = ~clk;

  pam4_lane_framer #(.ROWS(TR), .SYMS_PER_ROW(TS), .OVH_SYMS(TO)) u_pam4_lane_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ovh_bits(ovh_bits), .out_valid(out_valid),
    .out_ready(out_ready), .out_sym(out_sym), .out_term(out_term)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic bitv(input int i);
    logic [11:0] v;
    v = 12'b1010_0011_1000;
    if (i < 12) return v[11-i];
    return (((i * 13) + (i / 7)) % 5) < 2;
  endfunction

  function automatic logic [3:0] ovh_pat(input int f);
    if (f == 0) return 4'b1010;
    return 4'(((f * 5) + 3) % 16);
  endfunction

  function automatic logic [1:0] gray_of(input logic [1:0] l);
    case (l)
      2'd0: return 2'b00;
      2'd1: return 2'b01;
      2'd2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  initial begin
    int k = 0, ip = 0, eb = 0, cyc = 0, nterm = 0;
    logic [1:0] mprev = 2'd2;
    logic hold_pend = 1'b0;
    logic [1:0] hold_sym = 2'b00;
    logic hold_term = 1'b0;
    int ref_lvl [8] = '{0, 2, 0, 2, 2, 1, 1, 3};

    rst_n = 1'b0; in_valid = 1'b0; in_data = 1'b0; out_ready = 1'b0;
    ovh_bits = ovh_pat(0);
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b0, "R9 in_ready during first overhead slot", in_ready, 0);
    rst_n = 1'b1;

    while (k < NSYM && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      if (k < 120) begin
        in_valid = 1'b1; out_ready = 1'b1;
      end else if (k < 360) begin
        in_valid = (cyc % 3) != 1; out_ready = (cyc % 4) != 3;
      end else begin
        in_valid = (cyc % 7) < 3; out_ready = ((cyc % 5) == 0) || ((cyc % 5) == 3);
      end
      in_data = bitv(ip);
      #1;
      ovh_bits = ovh_pat((k + (out_valid ? 1 : 0)) / FS);

      if (hold_pend) begin
        chk(out_valid == 1'b1, "R8 valid held under stall", out_valid, 1);
        chk(out_sym == hold_sym, "R8 symbol held under stall", out_sym, hold_sym);
        chk(out_term == hold_term, "R8 marker held under stall", out_term, hold_term);
      end

      if (out_valid && out_ready) begin
        int s, c;
        logic [1:0] x, lvl;
        logic [3:0] ov;
        logic eterm;
        string req;
        s = k % FS;
        c = s % TS;
        eterm = 1'b0;
        if (s < TO) begin
          ov = ovh_pat(k / FS);
          x = ov[3-2*s -: 2];
          lvl = x - mprev;
          req = "R2 overhead symbol";
        end else if (c == TS - 1) begin
          lvl = bitv(eb) ? 2'd3 : 2'd0;
          eb += 1;
          eterm = 1'b1;
          nterm++;
          req = "R5 termination symbol";
        end else begin
          x = {bitv(eb), bitv(eb + 1)};
          eb += 2;
          lvl = x - mprev;
          req = "R3 payload symbol";
        end
        mprev = lvl;
        chk(out_sym == gray_of(lvl), req, out_sym, gray_of(lvl));
        chk(out_term == eterm, "R7 termination marker", out_term, eterm);
        if (k < 8)
          chk(out_sym == gray_of(2'(ref_lvl[k])), "R4 reference precoder vector",
              out_sym, gray_of(2'(ref_lvl[k])));
        if (k < 4 && !eterm)
          chk(out_sym == gray_of(lvl), "R6 Gray code of level", out_sym, gray_of(lvl));
        k++;
      end

      hold_pend = out_valid && !out_ready;
      hold_sym  = out_sym;
      hold_term = out_term;
      if (in_valid && in_ready) ip++;
    end

    if (cyc >= LIMIT) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d symbols", k, NSYM);
    end else begin
      chk(eb == NF * (TR * (2 * TS - 1) - 2 * TO), "R1 payload bits per frame",
          eb, NF * (TR * (2 * TS - 1) - 2 * TO));
      chk(nterm == NF * TR, "R1 termination symbols per frame", nterm, NF * TR);
      chk(ip >= eb && ip <= eb + 1, "R8 no lost or extra input bits", ip, eb);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule